// File: doc/BRIEF.md
# Coprocessor Register Transfer Unit

This block executes register-move instructions between a host CPU and a vector coprocessor. The vector path moves a whole 128-bit coprocessor vector register to or from a 128-bit host register. The control path moves a 32-bit coprocessor control register to or from a 64-bit host register. The block holds the vector register file and the control register file. It applies write rules to each control index:

- some indices are read-only;
- one index holds reset/break requests, and writes to it are masked;
- one index starts the second vector unit when it is written.

The host presents one instruction at a time with `op_valid`. The instruction carries its kind, an interlock flag, a host register index, a coprocessor register index and the host register contents. A move toward the host comes back on the `host_we`/`host_widx`/`host_wdata` port one cycle after the instruction is accepted. When the interlock flag is set and the first vector unit reports that it is running, `stall` goes high. The host then holds the instruction until the unit stops. The block also emits single-cycle pulses for the following:

- reset of each of the two vector units;
- force-break of each of the two vector units;
- start of the second unit, with its start address.

Top module: `cop_xfer`

## Requirements
- R1: A vector move into the coprocessor (`op_kind`=2'b01) writes all 128 bits of `op_hdata` to vector register `op_cidx`. With `op_cidx`=0 the move is dropped, and vector index 0 always reads as zero.
- R2: A move toward the host (`op_kind` 2'b00 vector, 2'b10 control) raises `host_we` for one cycle, in the cycle after acceptance, with `host_widx`=`op_hidx`. A vector read sets `host_wide`=1 and returns the full 128-bit register. With `op_hidx`=0 no write-back occurs.
- R3: A control read (`op_kind`=2'b10) returns the 32-bit value in `host_wdata[31:0]` and copies of bit 31 in `host_wdata[63:32]`. It drives `host_wdata[127:64]` to zero and sets `host_wide`=0.
- R4: When `op_valid`, `op_interlock` and `stat_i[0]` are all high, `stall` is high and nothing changes: no register write, no write-back and no pulse. The instruction completes in the first cycle in which `stat_i[0]` is low. Without `op_interlock`, `stall` stays low.
- R5: Control writes (`op_kind`=2'b11) to indices 17, 26 and 29 are ignored. Reads of those indices return `mac_i`, `tpc_i` and `stat_i` respectively.
- R6: A control write to index 28 stores only the bits of the low host word selected by mask 0x0C0C. A later read returns the stored value.
- R7: In the cycle after a control write to index 28, `u0_brk`, `u0_rst`, `u1_brk` and `u1_rst` show bits 0, 1, 8 and 9 of the written word. Each pulse lasts one cycle.
- R8: A control write to index 27 pulses `u1_start` for one cycle with `u1_addr` equal to the low 16 bits of the word, but only if `stat_i[8]` is low when the write is accepted. Index 27 stores nothing and reads as zero.
- R9: A control write to any other non-zero index stores the low 32 bits of the host word unchanged. A write to index 0 is dropped, and index 0 reads as zero.
- R10: While `rst` is high and after it falls, `host_we`, `stall` (with `op_valid` low) and every pulse output are low, and all writable control registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction present; held by the host while `stall` is high |
| op_kind | input | 2 | 00 vector to host, 01 vector to coprocessor, 10 control to host, 11 control to coprocessor |
| op_interlock | input | 1 | Wait until the first unit stops before completing |
| op_hidx | input | 5 | Host register index |
| op_cidx | input | 5 | Coprocessor vector or control register index |
| op_hdata | input | 128 | Current contents of the host source register |
| stat_i | input | 32 | Unit status: bit 0 first unit running, bit 8 second unit busy |
| mac_i | input | 32 | Read-only MAC flag value |
| tpc_i | input | 32 | Read-only program counter value |
| stall | output | 1 | Instruction waiting on the interlock |
| host_we | output | 1 | Host register write-back strobe |
| host_widx | output | 5 | Host register index to write |
| host_wide | output | 1 | 1: all 128 bits valid; 0: only the low 64 bits |
| host_wdata | output | 128 | Write-back data |
| u0_brk | output | 1 | Force-break pulse, first unit |
| u0_rst | output | 1 | Reset pulse, first unit |
| u1_brk | output | 1 | Force-break pulse, second unit |
| u1_rst | output | 1 | Reset pulse, second unit |
| u1_start | output | 1 | Start pulse, second unit |
| u1_addr | output | 16 | Start address sent with `u1_start` |

## Verification
The interlock release and the start gating both read the status input in the same accepting cycle. The bench holds an interlocked write to the start index while both status bits 0 and 8 are set. It then drops bit 0 in the same cycle that bit 8 either falls or stays high. A start pulse is expected only in the first case, and in neither case before the release. The bench sweeps every control and vector index and compares against a model of the per-index rules, which covers write-back and per-index write behaviour together.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
  typedef enum logic [1:0] {
    XF_VEC_TO_HOST = 2'b00,
    XF_VEC_TO_COP  = 2'b01,
    XF_CTL_TO_HOST = 2'b10,
    XF_CTL_TO_COP  = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/cop_xfer_vrf.sv
module cop_xfer_vrf #(
  parameter int W     = 128,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  // write port plus synchronous read port, shaped for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cop_xfer_crf.sv
module cop_xfer_crf #(
  parameter int IDX_W    = 5,
  parameter int DW       = 32,
  parameter int HW       = 64,
  parameter int ADDR_W   = 16,
  parameter logic [IDX_W-1:0] IDX_MAC   = 5'd17,
  parameter logic [IDX_W-1:0] IDX_TPC   = 5'd26,
  parameter logic [IDX_W-1:0] IDX_START = 5'd27,
  parameter logic [IDX_W-1:0] IDX_RB    = 5'd28,
  parameter logic [IDX_W-1:0] IDX_STAT  = 5'd29,
  parameter logic [DW-1:0]    RB_MASK   = 32'h0000_0C0C,
  parameter int BRK0_BIT = 0,
  parameter int RST0_BIT = 1,
  parameter int BRK1_BIT = 8,
  parameter int RST1_BIT = 9,
  parameter int BUSY_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     stat_i,
  input  logic [DW-1:0]     mac_i,
  input  logic [DW-1:0]     tpc_i,
  output logic [HW-1:0]     rdata,
  output logic              u0_brk_o,
  output logic              u0_rst_o,
  output logic              u1_brk_o,
  output logic              u1_rst_o,
  output logic              u1_start_o,
  output logic [ADDR_W-1:0] u1_addr_o
);
  localparam int NREG = 2 ** IDX_W;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_val;

  // one storage slot per index; read-only and command indices keep none
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    localparam bit STORE = !(GI == '0 || GI == IDX_MAC || GI == IDX_TPC ||
                             GI == IDX_STAT || GI == IDX_START);
    localparam logic [DW-1:0] KEEP = (GI == IDX_RB) ? RB_MASK : '1;
    if (STORE) begin : g_st
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                     q <= '0;
        else if (wr_en && idx == GI) q <= wdata & KEEP;
      end
      assign regs[g] = q;
    end else begin : g_none
      assign regs[g] = '0;
    end
  end

  always_comb begin
    rd_val = regs[idx];
    if (idx == IDX_MAC)  rd_val = mac_i;
    if (idx == IDX_TPC)  rd_val = tpc_i;
    if (idx == IDX_STAT) rd_val = stat_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(HW-DW){rd_val[DW-1]}}, rd_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u0_brk_o   <= 1'b0;
      u0_rst_o   <= 1'b0;
      u1_brk_o   <= 1'b0;
      u1_rst_o   <= 1'b0;
      u1_start_o <= 1'b0;
      u1_addr_o  <= '0;
    end else begin
      u0_brk_o   <= 1'b0;
      u0_rst_o   <= 1'b0;
      u1_brk_o   <= 1'b0;
      u1_rst_o   <= 1'b0;
      u1_start_o <= 1'b0;
      if (wr_en && idx == IDX_RB) begin
        u0_brk_o <= wdata[BRK0_BIT];
        u0_rst_o <= wdata[RST0_BIT];
        u1_brk_o <= wdata[BRK1_BIT];
        u1_rst_o <= wdata[RST1_BIT];
      end
      if (wr_en && idx == IDX_START && !stat_i[BUSY_BIT]) begin
        u1_start_o <= 1'b1;
        u1_addr_o  <= wdata[ADDR_W-1:0];
      end
    end
  end

  // R7: a unit pulse only follows a write to the reset/break index
  a_r7_pulse_source: assert property (@(posedge clk) disable iff (rst)
    (u0_brk_o || u0_rst_o || u1_brk_o || u1_rst_o) |-> $past(wr_en && idx == IDX_RB));

  // R8: a start pulse never follows a write seen while the second unit was busy
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    u1_start_o |-> $past(wr_en && !stat_i[BUSY_BIT]));
endmodule

// File: rtl/cop_xfer.sv
module cop_xfer
  import cop_xfer_pkg::*;
#(
  parameter int VW       = 128,
  parameter int CW       = 32,
  parameter int HW       = 64,
  parameter int IDX_W    = 5,
  parameter int ADDR_W   = 16,
  parameter int RUN_BIT  = 0,
  parameter int BUSY_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_interlock,
  input  logic [IDX_W-1:0]  op_hidx,
  input  logic [IDX_W-1:0]  op_cidx,
  input  logic [VW-1:0]     op_hdata,
  input  logic [CW-1:0]     stat_i,
  input  logic [CW-1:0]     mac_i,
  input  logic [CW-1:0]     tpc_i,
  output logic              stall,
  output logic              host_we,
  output logic [IDX_W-1:0]  host_widx,
  output logic              host_wide,
  output logic [VW-1:0]     host_wdata,
  output logic              u0_brk,
  output logic              u0_rst,
  output logic              u1_brk,
  output logic              u1_rst,
  output logic              u1_start,
  output logic [ADDR_W-1:0] u1_addr
);
  localparam int NREG = 2 ** IDX_W;

  xfer_kind_e kind;
  logic accept, vec_we, ctl_we, to_host;
  logic vzero_q;
  logic [VW-1:0] vrf_q;
  logic [HW-1:0] crf_q;

  assign kind    = xfer_kind_e'(op_kind);
  assign stall   = op_valid && op_interlock && stat_i[RUN_BIT];
  assign accept  = op_valid && !stall;
  assign vec_we  = accept && kind == XF_VEC_TO_COP && op_cidx != '0;
  assign ctl_we  = accept && kind == XF_CTL_TO_COP && op_cidx != '0;
  assign to_host = accept && (kind == XF_VEC_TO_HOST || kind == XF_CTL_TO_HOST) &&
                   op_hidx != '0;

  cop_xfer_vrf #(.W(VW), .DEPTH(NREG)) i_vrf (
    .clk  (clk),
    .we   (vec_we),
    .waddr(op_cidx),
    .wdata(op_hdata),
    .raddr(op_cidx),
    .rdata(vrf_q)
  );

  cop_xfer_crf #(
    .IDX_W(IDX_W), .DW(CW), .HW(HW), .ADDR_W(ADDR_W), .BUSY_BIT(BUSY_BIT)
  ) i_crf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_we),
    .idx       (op_cidx),
    .wdata     (op_hdata[CW-1:0]),
    .stat_i    (stat_i),
    .mac_i     (mac_i),
    .tpc_i     (tpc_i),
    .rdata     (crf_q),
    .u0_brk_o  (u0_brk),
    .u0_rst_o  (u0_rst),
    .u1_brk_o  (u1_brk),
    .u1_rst_o  (u1_rst),
    .u1_start_o(u1_start),
    .u1_addr_o (u1_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_we   <= 1'b0;
      host_widx <= '0;
      host_wide <= 1'b0;
      vzero_q   <= 1'b0;
    end else begin
      host_we   <= to_host;
      host_widx <= op_hidx;
      host_wide <= kind == XF_VEC_TO_HOST;
      vzero_q   <= op_cidx == '0;
    end
  end

  assign host_wdata = host_wide ? (vzero_q ? '0 : vrf_q) : {{(VW-HW){1'b0}}, crf_q};

  // R2: write-back never targets host index zero
  a_r2_dest_nonzero: assert property (@(posedge clk) disable iff (rst)
    host_we |-> host_widx != '0);

  // R3: a narrow write-back carries a sign-extended word and a clear upper half
  a_r3_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (host_we && !host_wide) |->
      (host_wdata[HW-1:CW] == {(HW-CW){host_wdata[CW-1]}} && host_wdata[VW-1:HW] == '0));

  // R4: a stalled instruction produces no write-back and no start in the next cycle
  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_valid && stall) |=> (!host_we && !u1_start && !u0_rst && !u1_rst));
endmodule

// File: tb/test_cop_xfer.sv
`timescale 1ns/1ps
module test_cop_xfer;
  localparam int I_MAC = 17, I_TPC = 26, I_START = 27, I_RB = 28, I_STAT = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic op_interlock = 1'b0;
  logic [4:0] op_hidx = '0, op_cidx = '0;
  logic [127:0] op_hdata = '0;
  logic [31:0] stat_i = '0;
  logic [31:0] mac_i = 32'h8000_1234;
  logic [31:0] tpc_i = 32'h0000_0ABC;
  logic stall, host_we, host_wide, u0_brk, u0_rst, u1_brk, u1_rst, u1_start;
  logic [4:0] host_widx;
  logic [127:0] host_wdata;
  logic [15:0] u1_addr;

  int n_chk = 0, n_err = 0;
  logic [31:0] mdl [32];

  always #2 clk = ~clk;

  cop_xfer i_cop_xfer (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_interlock(op_interlock), .op_hidx(op_hidx), .op_cidx(op_cidx),
    .op_hdata(op_hdata), .stat_i(stat_i), .mac_i(mac_i), .tpc_i(tpc_i),
    .stall(stall), .host_we(host_we), .host_widx(host_widx), .host_wide(host_wide),
    .host_wdata(host_wdata), .u0_brk(u0_brk), .u0_rst(u0_rst), .u1_brk(u1_brk),
    .u1_rst(u1_rst), .u1_start(u1_start), .u1_addr(u1_addr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] vpat(input int i);
    logic [31:0] s = 32'(i) * 32'h9E37_79B9 + 32'h1357_2468;
    return {s, ~s, s ^ 32'hA5A5_0F0F, s + 32'd7};
  endfunction

  function automatic logic [31:0] cpat(input int i);
    return (32'(i) * 32'h1111_1111) ^ ((i % 2 == 1) ? 32'h8000_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] exp_rd(input int c);
    if (c == I_MAC)  return mac_i;
    if (c == I_TPC)  return tpc_i;
    if (c == I_STAT) return stat_i;
    return mdl[c];
  endfunction

  function automatic void mdl_wr(input int c, input logic [31:0] d);
    if (c == 0 || c == I_MAC || c == I_TPC || c == I_STAT || c == I_START) return;
    mdl[c] = (c == I_RB) ? (d & 32'h0C0C) : d;
  endfunction

  function automatic logic [127:0] sext(input logic [31:0] v);
    return {64'h0, {32{v[31]}}, v};
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic go(input logic [1:0] k, input logic il, input logic [4:0] h,
                    input logic [4:0] c, input logic [127:0] d);
    op_valid = 1'b1; op_kind = k; op_interlock = il;
    op_hidx = h; op_cidx = c; op_hdata = d;
    @(negedge clk);
    op_valid = 1'b0; op_interlock = 1'b0;
  endtask

  task automatic chk_pulses(input string req, input logic [4:0] exp);
    chk(req, {123'h0, u0_brk, u0_rst, u1_brk, u1_rst, u1_start}, {123'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 we", {127'h0, host_we}, 128'h0);
    chk("R10 stall", {127'h0, stall}, 128'h0);
    chk_pulses("R10 pulses", 5'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_pulses("R10 pulses after reset", 5'b0);
    for (int c = 0; c < 32; c++) begin
      go(2'b10, 1'b0, 5'd3, 5'(c), '0);
      chk("R10 reset value", host_wdata, sext(exp_rd(c)));
    end

    // R1: vector writes at every index
    for (int i = 0; i < 32; i++) go(2'b01, 1'b0, 5'd1, 5'(i), vpat(i));
    // R2: vector reads back, index 0 reads zero (R1)
    for (int i = 0; i < 32; i++) begin
      go(2'b00, 1'b0, 5'(i == 0 ? 9 : i), 5'(i), '0);
      chk("R2 we", {127'h0, host_we}, 128'h1);
      chk("R2 idx", {123'h0, host_widx}, {123'h0, 5'(i == 0 ? 9 : i)});
      chk("R2 wide", {127'h0, host_wide}, 128'h1);
      chk("R1 data", host_wdata, (i == 0) ? 128'h0 : vpat(i));
    end
    go(2'b00, 1'b0, 5'd0, 5'd4, '0);
    chk("R2 dest zero dropped", {127'h0, host_we}, 128'h0);
    go(2'b10, 1'b0, 5'd0, 5'd4, '0);
    chk("R2 ctl dest zero dropped", {127'h0, host_we}, 128'h0);

    // R5 R6 R7 R8 R9: control writes at every index
    stat_i = 32'h0;
    for (int c = 0; c < 32; c++) begin
      logic [31:0] d = cpat(c);
      go(2'b11, 1'b0, 5'd2, 5'(c), {96'hDEAD, d});
      mdl_wr(c, d);
      chk_pulses("R7 R8 write pulses",
        (c == I_RB) ? {d[0], d[1], d[8], d[9], 1'b0} : {4'b0, (c == I_START)});
      if (c == I_START) chk("R8 address", {112'h0, u1_addr}, {112'h0, d[15:0]});
      @(negedge clk);
      chk_pulses("R7 single cycle", 5'b0);
    end
    for (int c = 0; c < 32; c++) begin
      go(2'b10, 1'b0, 5'd5, 5'(c), '0);
      chk("R3 wide", {127'h0, host_wide}, 128'h0);
      chk("R9 R5 R6 R8 read", host_wdata, sext(exp_rd(c)));
    end

    // R6 R7: reset/break with all ones, then a sparse pattern
    go(2'b11, 1'b0, 5'd1, 5'(I_RB), {96'h0, 32'hFFFF_FFFF});
    mdl_wr(I_RB, 32'hFFFF_FFFF);
    chk_pulses("R7 all pulses", 5'b11110);
    go(2'b10, 1'b0, 5'd6, 5'(I_RB), '0);
    chk("R6 masked", host_wdata, sext(32'h0000_0C0C));
    go(2'b11, 1'b0, 5'd1, 5'(I_RB), {96'h0, 32'h0000_0102});
    chk_pulses("R7 sparse pulses", 5'b01100);

    // R8: busy second unit blocks start
    stat_i = 32'h0000_0100;
    go(2'b11, 1'b0, 5'd1, 5'(I_START), {96'h0, 32'h0000_4321});
    chk_pulses("R8 busy no start", 5'b0);
    go(2'b10, 1'b0, 5'd6, 5'(I_STAT), '0);
    chk("R5 status read", host_wdata, sext(32'h0000_0100));

    // R4: running unit without interlock does not stall
    stat_i = 32'h0000_0001;
    op_valid = 1'b1; op_interlock = 1'b0; op_kind = 2'b10;
    #0.5;
    chk("R4 no interlock no stall", {127'h0, stall}, 128'h0);
    op_valid = 1'b0;
    @(negedge clk);

    // R4: interlocked control write waits, no state change
    op_valid = 1'b1; op_interlock = 1'b1; op_kind = 2'b11;
    op_hidx = 5'd1; op_cidx = 5'd5; op_hdata = {96'h0, 32'hCAFE_F00D};
    for (int k = 0; k < 3; k++) begin
      #0.5;
      chk("R4 stall high", {127'h0, stall}, 128'h1);
      @(negedge clk);
      chk("R4 no write-back", {127'h0, host_we}, 128'h0);
    end
    stat_i = 32'h0;
    @(negedge clk);
    op_valid = 1'b0; op_interlock = 1'b0;
    mdl_wr(5, 32'hCAFE_F00D);
    go(2'b10, 1'b0, 5'd7, 5'd5, '0);
    chk("R4 completes after release", host_wdata, sext(32'hCAFE_F00D));

    // R4: interlocked read waits for release
    stat_i = 32'h1;
    op_valid = 1'b1; op_interlock = 1'b1; op_kind = 2'b00;
    op_hidx = 5'd8; op_cidx = 5'd12;
    @(negedge clk);
    chk("R4 read held", {127'h0, host_we}, 128'h0);
    stat_i = 32'h0;
    @(negedge clk);
    op_valid = 1'b0; op_interlock = 1'b0;
    chk("R4 read after release", host_wdata, vpat(12));
    chk("R4 read strobe", {127'h0, host_we}, 128'h1);

    // R4 with R8: release and busy bit change in the same cycle
    stat_i = 32'h0000_0101;
    op_valid = 1'b1; op_interlock = 1'b1; op_kind = 2'b11;
    op_cidx = 5'(I_START); op_hdata = {96'h0, 32'h0000_7E57};
    @(negedge clk);
    chk_pulses("R8 no start while stalled", 5'b0);
    stat_i = 32'h0;
    @(negedge clk);
    op_valid = 1'b0; op_interlock = 1'b0;
    chk_pulses("R8 start at release", 5'b00001);
    chk("R8 release address", {112'h0, u1_addr}, {112'h0, 16'h7E57});

    stat_i = 32'h0000_0101;
    op_valid = 1'b1; op_interlock = 1'b1; op_kind = 2'b11;
    op_cidx = 5'(I_START); op_hdata = {96'h0, 32'h0000_1111};
    @(negedge clk);
    stat_i = 32'h0000_0100;
    @(negedge clk);
    op_valid = 1'b0; op_interlock = 1'b0;
    chk_pulses("R8 busy at release no start", 5'b0);
    chk("R4 released", {127'h0, stall}, 128'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule